// File: doc/BRIEF.md
# Pointer Tag Version Checker

This block screens every load and store a core issues against a small version tag held for each 64-byte line of memory. A 64-bit pointer carries a 4-bit version in its top four bits. The block compares that version with the tag stored for the addressed line and reports whether the access may proceed. A stored tag of 4'hF marks a line that is being relocated. Any reference to such a line is reported with its own cause code, so that a user-level handler can step in.

The same block also produces the effective address. A configurable number of upper pointer bits (8, 16, 24 or 32) carry software metadata, and the block clears them before the address is used. The line tags live in a small internal table, indexed by the line number taken from the effective address. The table is updated through a separate write port that bypasses the check.

Results come back one cycle after the request, with a valid strobe. When checking is switched off, the block still masks the address but always reports a pass.

Top module: `ptag_checker`

## Requirements
- R1: `rsp_valid_o` is high in the cycle after `req_valid_i` was high, and low in the cycle after it was low.
- R2: `mask_sel_i` values 0, 1, 2 and 3 clear the top 8, 16, 24 and 32 pointer bits of `rsp_addr_o`. All lower bits pass through unchanged.
- R3: The tag table index is effective-address bits [6 +: IDX_W]. Bits [5:0], and bits above the index field, do not change which tag is used.
- R4: With checking on, a pointer version (bits [63:60]) from 1 to 14 that differs from a non-migrating stored tag gives `rsp_cause_o` = 1 (mismatch) and `rsp_pass_o` = 0.
- R5: With checking on, a pointer version equal to the stored tag (stored tag not 4'hF) gives cause 0 and pass 1.
- R6: Pointer versions 4'h0 and 4'hF match any stored tag other than 4'hF and give cause 0.
- R7: With checking on, a stored tag of 4'hF gives cause 2 (migrating) and pass 0 for every pointer version, for loads and stores alike.
- R8: With `check_en_i` low, the result is cause 0 and pass 1 whatever the tags are, and the address is still masked.
- R9: A tag write takes effect from the next cycle on. A request in the same cycle as a write to its line sees the old tag.
- R10: After reset, every stored tag is 4'h0 and `rsp_valid_o` is low.
- R11: Loads and stores (`req_is_store_i` 0 or 1) receive the same verdict for the same pointer and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_ptr_i | input | 64 | Tagged virtual pointer |
| req_is_store_i | input | 1 | 1 for a store, 0 for a load |
| mask_sel_i | input | 2 | Metadata width: 0=8, 1=16, 2=24, 3=32 bits |
| check_en_i | input | 1 | Version checking enable |
| tag_wr_en_i | input | 1 | Tag table write strobe |
| tag_wr_line_i | input | IDX_W | Line index to write |
| tag_wr_ver_i | input | 4 | New tag for that line |
| rsp_valid_o | output | 1 | Result strobe, one cycle after the request |
| rsp_addr_o | output | 64 | Masked effective address |
| rsp_pass_o | output | 1 | Access allowed |
| rsp_cause_o | output | 2 | 0 pass, 1 mismatch, 2 migrating |

## Verification
The assertions assume that `mask_sel_i` and `check_en_i` are stable, known values whenever `req_valid_i` is high. They also assume that the pointer version is compared only after reset has cleared the table.

The stimulus drives every input from the falling clock edge, so all of them settle before the sampling edge. It keeps the mask selection within its four legal codes. It places same-cycle tag writes and requests deliberately, so the old-tag-versus-new-tag ordering is exercised on purpose and not by chance.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
    localparam int PTR_W     = 64;
    localparam int VER_W     = 4;
    localparam int LINE_LSB  = 6;
    localparam int MASK_STEP = 8;
    localparam logic [VER_W-1:0] VER_MIGRATE = '1;
    localparam logic [VER_W-1:0] VER_ANY_LO  = '0;

    typedef enum logic [1:0] {
        CAUSE_OK       = 2'd0,
        CAUSE_MISMATCH = 2'd1,
        CAUSE_MIGRATE  = 2'd2
    } cause_e;

    typedef struct packed {
        logic             vld;
        logic [PTR_W-1:0] addr;
        cause_e           cause;
    } rsp_t;
endpackage

// File: rtl/ptag_addr_mask.sv
module ptag_addr_mask
    import ptag_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       sel_i,
    output logic [PTR_W-1:0] addr_o
);
    localparam int NSEL = 4;

    logic [PTR_W-1:0] keep_tbl [NSEL];
    logic [PTR_W-1:0] keep;

    // One keep mask per metadata width, built by generate.
    for (genvar g = 0; g < NSEL; g++) begin : g_keep
        localparam int KEEP_BITS = PTR_W - MASK_STEP * (g + 1);
        assign keep_tbl[g] = {{(PTR_W-KEEP_BITS){1'b0}}, {KEEP_BITS{1'b1}}};
    end

    always_comb begin
        keep   = keep_tbl[sel_i];
        addr_o = ptr_i & keep;
    end
endmodule

// File: rtl/ptag_tag_table.sv
module ptag_tag_table
    import ptag_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [VER_W-1:0] rd_ver_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VER_W-1:0] wr_ver_i
);
    logic [VER_W-1:0] tag_d [ENTRIES];
    logic [VER_W-1:0] tag_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tag_d[i] = tag_q[i];
        end
        if (wr_en_i) begin
            tag_d[wr_idx_i] = wr_ver_i;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_ni) tag_q[i] <= '0;
            else         tag_q[i] <= tag_d[i];
        end
    end

    // Read sees contents before this cycle's write.
    assign rd_ver_o = tag_q[rd_idx_i];
endmodule

// File: rtl/ptag_verdict.sv
module ptag_verdict
    import ptag_pkg::*;
(
    input  logic             en_i,
    input  logic [VER_W-1:0] ptr_ver_i,
    input  logic [VER_W-1:0] line_ver_i,
    output cause_e           cause_o
);
    logic universal;

    always_comb begin
        universal = (ptr_ver_i == VER_ANY_LO) || (ptr_ver_i == VER_MIGRATE);
        if (!en_i) begin
            cause_o = CAUSE_OK;
        end else if (line_ver_i == VER_MIGRATE) begin
            cause_o = CAUSE_MIGRATE;
        end else if (universal || (ptr_ver_i == line_ver_i)) begin
            cause_o = CAUSE_OK;
        end else begin
            cause_o = CAUSE_MISMATCH;
        end
    end
endmodule

// File: rtl/ptag_checker.sv
module ptag_checker
    import ptag_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [63:0]      req_ptr_i,
    input  logic             req_is_store_i,
    input  logic [1:0]       mask_sel_i,
    input  logic             check_en_i,
    input  logic             tag_wr_en_i,
    input  logic [IDX_W-1:0] tag_wr_line_i,
    input  logic [3:0]       tag_wr_ver_i,
    output logic             rsp_valid_o,
    output logic [63:0]      rsp_addr_o,
    output logic             rsp_pass_o,
    output logic [1:0]       rsp_cause_o
);
    logic [PTR_W-1:0] eff_addr;
    logic [VER_W-1:0] line_ver;
    cause_e           cause;
    rsp_t             rsp_d, rsp_q;
    logic             unused_access_type;

    // Loads and stores are checked identically.
    assign unused_access_type = req_is_store_i;

    ptag_addr_mask u_mask (
        .ptr_i  (req_ptr_i),
        .sel_i  (mask_sel_i),
        .addr_o (eff_addr)
    );

    ptag_tag_table #(.ENTRIES(ENTRIES)) u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_idx_i (eff_addr[LINE_LSB +: IDX_W]),
        .rd_ver_o (line_ver),
        .wr_en_i  (tag_wr_en_i),
        .wr_idx_i (tag_wr_line_i),
        .wr_ver_i (tag_wr_ver_i)
    );

    ptag_verdict u_verdict (
        .en_i       (check_en_i),
        .ptr_ver_i  (req_ptr_i[PTR_W-1 -: VER_W]),
        .line_ver_i (line_ver),
        .cause_o    (cause)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.vld   = req_valid_i;
        if (req_valid_i) begin
            rsp_d.addr  = eff_addr;
            rsp_d.cause = cause;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rsp_q <= '{vld: 1'b0, addr: '0, cause: CAUSE_OK};
        else         rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.vld;
    assign rsp_addr_o  = rsp_q.addr;
    assign rsp_cause_o = rsp_q.cause;
    assign rsp_pass_o  = (rsp_q.cause == CAUSE_OK);
endmodule

// File: rtl/ptag_checker_sva.sv
module ptag_checker_sva (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_valid_i,
    input logic [63:0] req_ptr_i,
    input logic [1:0]  mask_sel_i,
    input logic        check_en_i,
    input logic        rsp_valid_o,
    input logic [63:0] rsp_addr_o,
    input logic        rsp_pass_o,
    input logic [1:0]  rsp_cause_o
);
    assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    assert_idle_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    assert_top_byte_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (rsp_addr_o[63:56] == 8'h00));

    assert_widest_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mask_sel_i == 2'd3) |=> (rsp_addr_o[63:32] == 32'h0));

    assert_low_bits_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (rsp_addr_o[31:0] == $past(req_ptr_i[31:0])));

    assert_universal_no_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && check_en_i && (req_ptr_i[63:60] == 4'h0 || req_ptr_i[63:60] == 4'hF))
        |=> (rsp_cause_o != 2'd1));

    assert_disabled_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !check_en_i) |=> (rsp_pass_o && rsp_cause_o == 2'd0));

    assert_legal_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (rsp_cause_o != 2'd3));
endmodule

bind ptag_checker ptag_checker_sva u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ptr_i   (req_ptr_i),
    .mask_sel_i  (mask_sel_i),
    .check_en_i  (check_en_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_addr_o  (rsp_addr_o),
    .rsp_pass_o  (rsp_pass_o),
    .rsp_cause_o (rsp_cause_o)
);

// File: tb/ptag_checker_tb.sv
module ptag_checker_tb_top;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [63:0]      req_ptr;
    logic             req_is_store;
    logic [1:0]       mask_sel;
    logic             check_en;
    logic             tag_wr_en;
    logic [IDX_W-1:0] tag_wr_line;
    logic [3:0]       tag_wr_ver;
    logic             rsp_valid;
    logic [63:0]      rsp_addr;
    logic             rsp_pass;
    logic [1:0]       rsp_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int          model_tag [ENTRIES];
    bit          exp_vld;
    logic [63:0] exp_addr;
    int          exp_cause;
    string       exp_tag;

    always #5 clk = ~clk;

    ptag_checker #(.ENTRIES(ENTRIES)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (req_valid),
        .req_ptr_i      (req_ptr),
        .req_is_store_i (req_is_store),
        .mask_sel_i     (mask_sel),
        .check_en_i     (check_en),
        .tag_wr_en_i    (tag_wr_en),
        .tag_wr_line_i  (tag_wr_line),
        .tag_wr_ver_i   (tag_wr_ver),
        .rsp_valid_o    (rsp_valid),
        .rsp_addr_o     (rsp_addr),
        .rsp_pass_o     (rsp_pass),
        .rsp_cause_o    (rsp_cause)
    );

    function automatic logic [63:0] mask_of(input logic [63:0] p, input int sel);
        int keep = 64 - 8 * (sel + 1);
        logic [63:0] m = '0;
        for (int b = 0; b < keep; b++) m[b] = 1'b1;
        return p & m;
    endfunction

    task automatic compare_prev();
        checks++;
        if (rsp_valid !== exp_vld) begin
            errors++;
            $display("FAIL R1 valid actual %0b expected %0b", rsp_valid, exp_vld);
        end
        if (exp_vld) begin
            checks++;
            if (rsp_addr !== exp_addr) begin
                errors++;
                $display("FAIL R2 %s addr actual %h expected %h", exp_tag, rsp_addr, exp_addr);
            end
            checks++;
            if (rsp_cause !== 2'(exp_cause) || rsp_pass !== (exp_cause == 0)) begin
                errors++;
                $display("FAIL %s cause/pass actual %0d/%0b expected %0d/%0b",
                         exp_tag, rsp_cause, rsp_pass, exp_cause, exp_cause == 0);
            end
        end
    endtask

    // One cycle: check last result, drive new inputs, update the model.
    task automatic step(input bit v, input logic [63:0] p, input bit st, input int sel,
                        input bit en, input bit we, input int wl, input int wv,
                        input string tag);
        int idx, pv, lv;
        @(negedge clk);
        compare_prev();
        req_valid = v; req_ptr = p; req_is_store = st; mask_sel = 2'(sel);
        check_en = en; tag_wr_en = we; tag_wr_line = IDX_W'(wl); tag_wr_ver = 4'(wv);
        exp_vld  = v;
        exp_tag  = tag;
        if (v) begin
            exp_addr = mask_of(p, sel);
            idx = int'(exp_addr[6 +: IDX_W]);
            pv  = int'(p[63:60]);
            lv  = model_tag[idx];
            if (!en)                         exp_cause = 0;
            else if (lv == 15)               exp_cause = 2;
            else if (pv == 0 || pv == 15)    exp_cause = 0;
            else if (pv != lv)               exp_cause = 1;
            else                             exp_cause = 0;
        end
        if (we) model_tag[wl] = wv;
    endtask

    function automatic logic [63:0] mk(input int ver, input int line, input int off);
        logic [63:0] p = '0;
        p[63:60] = 4'(ver);
        p[6 +: IDX_W] = IDX_W'(line);
        p[5:0] = 6'(off);
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) model_tag[i] = 0;
        exp_vld = 0; exp_addr = '0; exp_cause = 0; exp_tag = "R1";
        rst_n = 0; req_valid = 0; req_ptr = '0; req_is_store = 0; mask_sel = 0;
        check_en = 0; tag_wr_en = 0; tag_wr_line = '0; tag_wr_ver = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 valid after reset actual %0b expected 0", rsp_valid);
        end
        // R10: fresh table holds 0, so version 5 mismatches line 3
        step(1, mk(5, 3, 0), 0, 0, 1, 0, 0, 0, "R10");
        // R9: write and same-cycle read sees old tag
        step(1, mk(5, 3, 4), 0, 0, 1, 1, 3, 5, "R9");
        step(1, mk(5, 3, 8), 0, 0, 1, 0, 0, 0, "R9");
        // R5 match, R4 mismatch, R11 store
        step(1, mk(5, 3, 0), 0, 1, 1, 0, 0, 0, "R5");
        step(1, mk(6, 3, 0), 0, 2, 1, 0, 0, 0, "R4");
        step(1, mk(6, 3, 0), 1, 2, 1, 0, 0, 0, "R11");
        step(1, mk(5, 3, 0), 1, 3, 1, 0, 0, 0, "R11");
        // R6 universal versions
        step(1, mk(0, 3, 0), 0, 0, 1, 0, 0, 0, "R6");
        step(1, mk(15, 3, 0), 1, 0, 1, 0, 0, 0, "R6");
        // R7 migrating line
        step(1, mk(5, 3, 0), 0, 0, 1, 1, 7, 15, "R5");
        step(1, mk(0, 7, 0), 0, 0, 1, 0, 0, 0, "R7");
        step(1, mk(15, 7, 0), 1, 1, 1, 0, 0, 0, "R7");
        step(1, mk(9, 7, 63), 1, 0, 1, 0, 0, 0, "R7");
        // R8 disabled
        step(1, mk(9, 7, 0), 0, 0, 0, 0, 0, 0, "R8");
        step(1, mk(6, 3, 0) | 64'h00FF_0000_0000_0000, 0, 0, 0, 0, 0, 0, "R8");
        // R3 offset and high bits do not change the line
        step(1, mk(5, 3, 63), 0, 0, 1, 0, 0, 0, "R3");
        step(1, mk(5, 3, 17) | 64'h0000_0000_8000_0000, 0, 3, 1, 0, 0, 0, "R3");
        step(1, mk(5, 4, 0), 0, 0, 1, 0, 0, 0, "R3");
        // R2 each mask width on an all-ones pointer
        for (int s = 0; s < 4; s++)
            step(1, 64'h5FFF_FFFF_FFFF_FFFF, 0, s, 0, 0, 0, 0, "R2");
        // R1 idle gap
        step(0, '0, 0, 0, 1, 0, 0, 0, "R1");
        step(0, '0, 0, 0, 1, 0, 0, 0, "R1");
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [63:0] rp;
            rp = {$urandom, $urandom};
            step(($urandom % 4) != 0, rp, 1'($urandom), int'($urandom % 4),
                 ($urandom % 5) != 0, ($urandom % 3) == 0, int'($urandom % ENTRIES),
                 (($urandom % 6) == 0) ? 15 : int'($urandom % 16), "R5");
        end
        step(0, '0, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        compare_prev();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule